// File: doc/BRIEF.md
# Serial ADC Record Buffer

This block runs a serial-output ADC and stores every conversion as a framed record in a dual-port circular buffer. A conversion is requested either by a one-cycle pulse on `conv_start_i` or by a write to the control space. The sequencer first stores the trigger number and then the timestamp, both captured in the cycle the request is accepted. It then gives the ADC a one-cycle active-low start pulse. From that point it shifts in one serial bit in each cycle that the ADC data-valid line is high. Bits are packed MSB-first into 32-bit words, and the record closes when data-valid drops.

Two strobe/write/ack bus ports serve the host. The control port holds a command/status word, the received bit count, the buffer write pointer and a build-time identification constant. The data port is read-only and returns buffer words. The serial ADC input cannot be stalled, so the block applies no back-pressure. Every bit presented with data-valid high is taken in the cycle it appears. Every bus strobe is answered one cycle later.

Top module: `adc_record_buffer`

## Requirements
- R1: While `rst` is high, `busy_o` is 0, `adc_start_n_o` is 1, `adc_rst_n_o` is 0 and both acks are 0. After reset, the bit count and the write pointer read 0 and `adc_rst_n_o` is 1.
- R2: A conversion is accepted from a `conv_start_i` pulse, or from a control write to address 0 with wdata bit 0 set, but only while idle. `busy_o` rises at the following edge. A request that arrives while busy is ignored.
- R3: After accepting a request, the block writes the captured trigger number at the write pointer and the captured timestamp at the next address. It then drives `adc_start_n_o` low for exactly one cycle.
- R4: After the start pulse, each cycle with `adc_dav_i` high takes one bit. The first bit goes to bit 31 of the first sample word. Each completed 32-bit word is written at the next buffer address.
- R5: The first cycle with `adc_dav_i` low, after at least one bit, ends sampling. The next cycle is a closing cycle that writes any partial word left-aligned with zero fill. `busy_o` falls at the edge after the closing cycle.
- R6: Control address 1 reads the number of bits received in the latest conversion. The count is cleared when a conversion is accepted.
- R7: Control address 2 reads the write pointer, which is the next address to be written. It steps by one per buffer write and wraps modulo 2^ADDR_W.
- R8: A control write to address 0 with wdata bit 1 set clears the write pointer to 0.
- R9: Control address 3 reads the IDENT parameter, which defaults to 0xDEADBEEF.
- R10: Control address 0 reads busy in bit 0, with all other bits 0.
- R11: A data-port read returns the buffer word at `dat_addr`. Data-port writes change nothing, `dat_ack` follows `dat_stb` by one cycle, and `dat_err` is 0.
- R12: `ctl_ack` follows `ctl_stb` by one cycle, and `ctl_err` is 0. Writes to control addresses 1 to 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_stb | input | 1 | Control access strobe |
| ctl_we | input | 1 | Control write enable |
| ctl_addr | input | 2 | Control register address |
| ctl_wdata | input | 32 | Control write data |
| ctl_rdata | output | 32 | Control read data, valid with ack |
| ctl_ack | output | 1 | Control acknowledge |
| ctl_err | output | 1 | Control error, always 0 |
| dat_stb | input | 1 | Data port strobe |
| dat_we | input | 1 | Data port write flag (writes ignored) |
| dat_addr | input | ADDR_W | Buffer word address |
| dat_rdata | output | 32 | Buffer word read data |
| dat_ack | output | 1 | Data port acknowledge |
| dat_err | output | 1 | Data port error, always 0 |
| conv_start_i | input | 1 | External one-cycle conversion request |
| trig_num_i | input | 32 | Trigger number to store as header |
| tstamp_i | input | 32 | Timestamp to store as header |
| adc_start_n_o | output | 1 | ADC start, active low |
| adc_rst_n_o | output | 1 | ADC reset, active low |
| adc_dav_i | input | 1 | ADC serial data valid |
| adc_sdata_i | input | 1 | ADC serial data bit |
| busy_o | output | 1 | Conversion in progress |

## Verification
The assertions assume that `adc_dav_i` only goes high after the ADC start pulse of an accepted conversion. They also assume that every stream delivers at least one bit and that no pointer clear arrives while a record is being written. The stimulus keeps to these rules. The ADC responder waits for the observed start pulse before it raises data-valid, and it drops data-valid once its bit budget is spent. The pointer clear and the data-port write are issued only while `busy_o` is low. Data-port reads are also made only when idle, so a read never targets the address being written in the same cycle.

// File: rtl/adcrb_pkg.sv
package adcrb_pkg;
  localparam int WORD_W = 32;
  localparam int FILL_W = $clog2(WORD_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TRIG,
    ST_TIME,
    ST_GO,
    ST_SHIFT,
    ST_CLOSE
  } seq_state_t;
endpackage

// File: rtl/adcrb_ctrl.sv
module adcrb_ctrl
  import adcrb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W = 16,
  parameter logic [31:0] IDENT = 32'hDEADBEEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              busy,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic [ADDR_W-1:0] wptr,
  output logic [WORD_W-1:0] rdata,
  output logic              ack,
  output logic              start_req,
  output logic              ptr_clr
);
  logic              cmd_hit;
  logic [WORD_W-1:0] rd_mux;
  logic              unused_wdata;

  assign cmd_hit      = stb && we && (addr == 2'd0);
  assign start_req    = cmd_hit && wdata[0];
  assign ptr_clr      = cmd_hit && wdata[1];
  assign unused_wdata = ^wdata[WORD_W-1:2];

  always_comb begin
    case (addr)
      2'd0:    rd_mux = {{(WORD_W-1){1'b0}}, busy};
      2'd1:    rd_mux = {{(WORD_W-CNT_W){1'b0}}, bit_cnt};
      2'd2:    rd_mux = {{(WORD_W-ADDR_W){1'b0}}, wptr};
      default: rd_mux = IDENT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack   <= 1'b0;
      rdata <= '0;
    end else begin
      ack <= stb;
      if (stb && !we) rdata <= rd_mux;
    end
  end

  AST_CTL_ACK: assert property (@(posedge clk) disable iff (rst)
    stb |=> ack); // R12
  AST_CTL_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (rst)
    !stb |=> !ack); // R12
endmodule

// File: rtl/adcrb_seq.sv
module adcrb_seq
  import adcrb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic              ptr_clr,
  input  logic [WORD_W-1:0] trig_i,
  input  logic [WORD_W-1:0] time_i,
  input  logic              dav_i,
  input  logic              sdata_i,
  output logic              busy_o,
  output logic              adc_start_n_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic [CNT_W-1:0]  bit_cnt_o
);
  seq_state_t        st;
  logic [WORD_W-1:0] trig_q, time_q, shreg;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] wptr;
  logic              seen;
  logic [FILL_W-1:0] fill;
  logic [FILL_W:0]   shamt;
  logic              word_full;

  assign fill      = cnt[FILL_W-1:0];
  assign shamt     = (FILL_W+1)'(WORD_W) - {1'b0, fill};
  assign word_full = (fill == {FILL_W{1'b1}});

  always_comb begin
    wr_en_o   = 1'b0;
    wr_data_o = shreg;
    case (st)
      ST_TRIG: begin
        wr_en_o   = 1'b1;
        wr_data_o = trig_q;
      end
      ST_TIME: begin
        wr_en_o   = 1'b1;
        wr_data_o = time_q;
      end
      ST_SHIFT: begin
        if (dav_i && word_full) begin
          wr_en_o   = 1'b1;
          wr_data_o = {shreg[WORD_W-2:0], sdata_i};
        end
      end
      ST_CLOSE: begin
        if (fill != '0) begin
          wr_en_o   = 1'b1;
          wr_data_o = shreg << shamt;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      seen   <= 1'b0;
      wptr   <= '0;
      trig_q <= '0;
      time_q <= '0;
      shreg  <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start_req) begin
            st     <= ST_TRIG;
            trig_q <= trig_i;
            time_q <= time_i;
            cnt    <= '0;
            seen   <= 1'b0;
          end
        end
        ST_TRIG: st <= ST_TIME;
        ST_TIME: st <= ST_GO;
        ST_GO:   st <= ST_SHIFT;
        ST_SHIFT: begin
          if (dav_i) begin
            shreg <= {shreg[WORD_W-2:0], sdata_i};
            cnt   <= cnt + 1'b1;
            seen  <= 1'b1;
          end else if (seen) begin
            st <= ST_CLOSE;
          end
        end
        default: st <= ST_IDLE;
      endcase
      if (ptr_clr)      wptr <= '0;
      else if (wr_en_o) wptr <= wptr + 1'b1;
    end
  end

  assign busy_o        = (st != ST_IDLE);
  assign adc_start_n_o = (st != ST_GO);
  assign wr_addr_o     = wptr;
  assign bit_cnt_o     = cnt;

  AST_BUSY_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_req)); // R2
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !adc_start_n_o |=> adc_start_n_o); // R3
  AST_BUSY_FALLS_AFTER_CLOSE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> ($past(st) == ST_CLOSE)); // R5
  AST_PTR_STEP_WRAP: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && !ptr_clr) |=> (wptr == $past(wptr) + 1'b1)); // R7
  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ptr_clr |=> (wptr == '0)); // R8
endmodule

// File: rtl/adcrb_ram.sv
module adcrb_ram
  import adcrb_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_stb,
  input  logic              rd_we,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_ack
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_stb && !rd_we) rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_ack <= 1'b0;
    else     rd_ack <= rd_stb;
  end

  AST_DAT_ACK: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> rd_ack); // R11
endmodule

// File: rtl/adc_record_buffer.sv
module adc_record_buffer
  import adcrb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W = 16,
  parameter logic [31:0] IDENT = 32'hDEADBEEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_stb,
  input  logic              ctl_we,
  input  logic [1:0]        ctl_addr,
  input  logic [31:0]       ctl_wdata,
  output logic [31:0]       ctl_rdata,
  output logic              ctl_ack,
  output logic              ctl_err,
  input  logic              dat_stb,
  input  logic              dat_we,
  input  logic [ADDR_W-1:0] dat_addr,
  output logic [31:0]       dat_rdata,
  output logic              dat_ack,
  output logic              dat_err,
  input  logic              conv_start_i,
  input  logic [31:0]       trig_num_i,
  input  logic [31:0]       tstamp_i,
  output logic              adc_start_n_o,
  output logic              adc_rst_n_o,
  input  logic              adc_dav_i,
  input  logic              adc_sdata_i,
  output logic              busy_o
);
  logic              reg_start, ptr_clr, start_any, wr_en;
  logic [ADDR_W-1:0] wptr;
  logic [WORD_W-1:0] wr_data;
  logic [CNT_W-1:0]  bit_cnt;
  logic              adc_rst_q;

  assign start_any = reg_start || conv_start_i;
  assign ctl_err   = 1'b0;
  assign dat_err   = 1'b0;

  always_ff @(posedge clk) adc_rst_q <= !rst;
  assign adc_rst_n_o = adc_rst_q;

  adcrb_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDENT(IDENT)) u_ctrl (
    .clk(clk), .rst(rst), .stb(ctl_stb), .we(ctl_we), .addr(ctl_addr),
    .wdata(ctl_wdata), .busy(busy_o), .bit_cnt(bit_cnt), .wptr(wptr),
    .rdata(ctl_rdata), .ack(ctl_ack), .start_req(reg_start), .ptr_clr(ptr_clr)
  );

  adcrb_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .start_req(start_any), .ptr_clr(ptr_clr),
    .trig_i(trig_num_i), .time_i(tstamp_i), .dav_i(adc_dav_i),
    .sdata_i(adc_sdata_i), .busy_o(busy_o), .adc_start_n_o(adc_start_n_o),
    .wr_en_o(wr_en), .wr_addr_o(wptr), .wr_data_o(wr_data), .bit_cnt_o(bit_cnt)
  );

  adcrb_ram #(.ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wptr), .wr_data(wr_data),
    .rd_stb(dat_stb), .rd_we(dat_we), .rd_addr(dat_addr),
    .rd_data(dat_rdata), .rd_ack(dat_ack)
  );

  AST_RST_LINE: assert property (@(posedge clk)
    rst |=> !adc_rst_n_o); // R1
  AST_GO_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    !adc_start_n_o |-> busy_o); // R3
endmodule

// File: tb/adc_record_buffer_test.sv
`timescale 1ns/1ps
module adc_record_buffer_test;
  localparam int AW = 5;
  localparam int DEPTH = 1 << AW;
  localparam logic [31:0] ID = 32'hDEADBEEF;

  logic clk = 0;
  logic rst = 1;
  logic ctl_stb = 0, ctl_we = 0;
  logic [1:0] ctl_addr = 0;
  logic [31:0] ctl_wdata = 0;
  logic [31:0] ctl_rdata;
  logic ctl_ack, ctl_err;
  logic dat_stb = 0, dat_we = 0;
  logic [AW-1:0] dat_addr = 0;
  logic [31:0] dat_rdata;
  logic dat_ack, dat_err;
  logic conv_start_i = 0;
  logic [31:0] trig_num_i = 0, tstamp_i = 0;
  logic adc_start_n_o, adc_rst_n_o, busy_o;
  logic adc_dav_i = 0, adc_sdata_i = 0;

  int checks = 0, errors = 0;
  bit chk_on = 0;

  always #10 clk = ~clk;

  adc_record_buffer #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .ctl_stb(ctl_stb), .ctl_we(ctl_we), .ctl_addr(ctl_addr),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .ctl_ack(ctl_ack), .ctl_err(ctl_err),
    .dat_stb(dat_stb), .dat_we(dat_we), .dat_addr(dat_addr), .dat_rdata(dat_rdata),
    .dat_ack(dat_ack), .dat_err(dat_err), .conv_start_i(conv_start_i),
    .trig_num_i(trig_num_i), .tstamp_i(tstamp_i), .adc_start_n_o(adc_start_n_o),
    .adc_rst_n_o(adc_rst_n_o), .adc_dav_i(adc_dav_i), .adc_sdata_i(adc_sdata_i),
    .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge
  int m_phase = 0;
  int unsigned m_wptr = 0, m_cnt = 0;
  logic [31:0] m_word = 0, m_trig = 0, m_ts = 0;
  bit m_seen = 0;
  logic [31:0] m_mem [int];
  bit pend_c = 0, pend_d = 0, c_rd = 0, d_rd = 0;
  logic [31:0] exp_c = 0, exp_d = 0;
  string c_req = "R10";

  function automatic void m_write(input logic [31:0] v);
    m_mem[int'(m_wptr)] = v;
    m_wptr = (m_wptr + 1) % DEPTH;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_wptr = 0; m_cnt = 0; m_seen = 0;
      pend_c = 0; pend_d = 0; c_rd = 0; d_rd = 0;
    end else begin
      bit start, clr;
      pend_c = ctl_stb;
      c_rd = ctl_stb && !ctl_we;
      if (c_rd) begin
        case (ctl_addr)
          2'd0: begin exp_c = {31'd0, m_phase != 0}; c_req = "R10"; end
          2'd1: begin exp_c = m_cnt; c_req = "R6"; end
          2'd2: begin exp_c = m_wptr; c_req = "R7"; end
          default: begin exp_c = ID; c_req = "R9"; end
        endcase
      end
      pend_d = dat_stb;
      d_rd = dat_stb && !dat_we && m_mem.exists(int'(dat_addr));
      if (d_rd) exp_d = m_mem[int'(dat_addr)];
      start = conv_start_i || (ctl_stb && ctl_we && ctl_addr == 2'd0 && ctl_wdata[0]);
      clr = ctl_stb && ctl_we && ctl_addr == 2'd0 && ctl_wdata[1];
      case (m_phase)
        0: if (start) begin
             m_phase = 1; m_trig = trig_num_i; m_ts = tstamp_i; m_cnt = 0; m_seen = 0;
           end
        1: begin m_write(m_trig); m_phase = 2; end
        2: begin m_write(m_ts); m_phase = 3; end
        3: m_phase = 4;
        4: if (adc_dav_i) begin
             m_word = {m_word[30:0], adc_sdata_i};
             m_cnt++; m_seen = 1;
             if (m_cnt % 32 == 0) m_write(m_word);
           end else if (m_seen) m_phase = 5;
        default: begin
          if (m_cnt % 32 != 0) m_write(m_word << (32 - m_cnt % 32));
          m_phase = 0;
        end
      endcase
      if (clr) m_wptr = 0;
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      chk(busy_o === (m_phase != 0), "R2 busy", {31'd0, busy_o}, {31'd0, m_phase != 0});
      chk(adc_start_n_o === (m_phase != 3), "R3 adc start", {31'd0, adc_start_n_o}, {31'd0, m_phase != 3});
      chk(adc_rst_n_o === 1'b1, "R1 adc reset line", {31'd0, adc_rst_n_o}, 32'd1);
      chk(ctl_ack === pend_c, "R12 ctl ack", {31'd0, ctl_ack}, {31'd0, pend_c});
      chk(dat_ack === pend_d, "R11 dat ack", {31'd0, dat_ack}, {31'd0, pend_d});
      chk(ctl_err === 1'b0 && dat_err === 1'b0, "R11 err", {30'd0, ctl_err, dat_err}, 32'd0);
      if (c_rd && pend_c) chk(ctl_rdata === exp_c, c_req, ctl_rdata, exp_c);
      if (d_rd && pend_d) chk(dat_rdata === exp_d, "R4 R5 buffer word", dat_rdata, exp_d);
      c_rd = 0; d_rd = 0;
    end
  end

  task automatic ctl_access(input bit w, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    ctl_stb = 1; ctl_we = w; ctl_addr = a; ctl_wdata = d;
    @(negedge clk);
    ctl_stb = 0; ctl_we = 0; ctl_wdata = 0;
    @(negedge clk);
  endtask

  task automatic dat_access(input bit w, input int a);
    @(negedge clk);
    dat_stb = 1; dat_we = w; dat_addr = AW'(a);
    @(negedge clk);
    dat_stb = 0; dat_we = 0;
    @(negedge clk);
  endtask

  task automatic adc_run(input int nbits, input int seed, input bit poke);
    int guard = 0;
    while (adc_start_n_o !== 1'b0 && guard < 1000) begin
      @(negedge clk); guard++;
    end
    @(negedge clk);
    adc_dav_i = 0;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      adc_dav_i = 1;
      adc_sdata_i = ((seed * 31 + i * i * 7 + (i >> 3)) & 5) != 0;
      conv_start_i = poke && (i == 3);  // R2: request while busy
    end
    @(negedge clk);
    adc_dav_i = 0; adc_sdata_i = 0; conv_start_i = 0;
    guard = 0;
    while (busy_o !== 1'b0 && guard < 100) begin
      @(negedge clk); guard++;
    end
  endtask

  task automatic ext_start(input logic [31:0] t, input logic [31:0] s);
    @(negedge clk);
    trig_num_i = t; tstamp_i = s; conv_start_i = 1;
    @(negedge clk);
    conv_start_i = 0; trig_num_i = ~t; tstamp_i = ~s;
  endtask

  task automatic read_all_ctl;
    for (int a = 0; a < 4; a++) ctl_access(0, 2'(a), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(busy_o === 1'b0, "R1 busy", {31'd0, busy_o}, 0);
    chk(adc_start_n_o === 1'b1, "R1 start_n", {31'd0, adc_start_n_o}, 1);
    chk(adc_rst_n_o === 1'b0, "R1 adc_rst_n", {31'd0, adc_rst_n_o}, 0);
    chk(ctl_ack === 1'b0 && dat_ack === 1'b0, "R1 acks", {30'd0, ctl_ack, dat_ack}, 0);
    rst = 0;
    @(negedge clk);
    chk_on = 1;
    read_all_ctl();  // R1 R6 R7 R9 R10

    // Record A: register start, 40 bits, a request while busy
    trig_num_i = 32'h0000_0A11; tstamp_i = 32'h1234_5678;
    ctl_access(1, 2'd0, 32'h1);
    trig_num_i = 0; tstamp_i = 0;
    ctl_access(0, 2'd0, 0);  // R10 read while busy
    adc_run(40, 3, 1);
    read_all_ctl();
    for (int a = 0; a < 5; a++) dat_access(0, a);

    // Record B: external start, exactly two words
    ext_start(32'h0000_0B22, 32'hCAFE_0001);
    adc_run(64, 9, 0);
    read_all_ctl();
    for (int a = 4; a < 9; a++) dat_access(0, a);

    // R12: writes to read-only control registers
    ctl_access(1, 2'd1, 32'hFFFF_FFFF);
    ctl_access(1, 2'd2, 32'h0000_0011);
    ctl_access(1, 2'd3, 32'h0);
    read_all_ctl();

    // R11: data port write ignored
    dat_access(1, 2);
    dat_access(0, 2);

    // R8: pointer clear
    ctl_access(1, 2'd0, 32'h2);
    ctl_access(0, 2'd2, 0);

    // R7: several records wrap the buffer
    for (int r = 0; r < 5; r++) begin
      ext_start(32'h100 + r, 32'h2000 + r * 17);
      adc_run(192, 20 + r, 0);
    end
    read_all_ctl();
    for (int a = 0; a < DEPTH; a++) dat_access(0, a);

    // Short record of one bit
    trig_num_i = 32'h77; tstamp_i = 32'h88;
    ctl_access(1, 2'd0, 32'h1);
    adc_run(1, 1, 0);
    read_all_ctl();
    for (int a = 0; a < DEPTH; a++) dat_access(0, a);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule